// File: doc/BRIEF.md
# Dual-Window Heartbeat Watchdog

This block supervises a processor heartbeat line and requests a system reset when the line stops changing level. It has two timeout lengths. After every reset event it runs a long window, which gives software time to boot. The first heartbeat transition shortens the timeout to a brief normal window. From then on, every transition restarts that window. A rising edge and a falling edge count equally as a kick.

Time is measured in ticks of an external time base, and both window lengths are parameters in ticks. The heartbeat input is asynchronous. It passes through a synchroniser before edge detection. A reset sequencer supplies a level that is high while system reset is active and a one-clock strobe for each new reset event. An enable input lets the system switch the watchdog off. When the timer runs out, it emits a one-clock expiry pulse. It then stays idle in startup mode until the sequencer strobes the next reset event.

Top module: `dual_window_watchdog`

## Requirements
- R1: After `rstN` is released, `startupMode` reads 1 and `expirePulse` reads 0. The long window is already running, counted from the last clock edge of reset, so with a tick on every clock and no kick the pulse appears START_TICKS+1 clocks after release.
- R2: In startup mode with no kick, the expiry pulse is visible after the clock edge that follows the edge at which START_TICKS ticks have been counted since the window was cleared. If `resetEvent` is sampled at edge E, the pulse is visible after edge E+START_TICKS+1 when a tick arrives on every clock.
- R3: The first heartbeat transition in startup mode sets `startupMode` to 0 and clears the count. From then on, the window is NORMAL_TICKS ticks.
- R4: A low-to-high transition and a high-to-low transition are both kicks. A heartbeat pulse only one clock wide therefore gives two kicks. Transitions spaced closer than the normal window prevent expiry.
- R5: A heartbeat change that is first captured at clock edge k takes effect at edge k+2, one edge after it leaves the two-flop synchroniser. Mode and count change after edge k+2 and not earlier. In normal mode, the pulse is then visible after edge k+NORMAL_TICKS+3.
- R6: Expiry is a single-clock pulse. Afterwards `startupMode` reads 1, the count stays cleared, and heartbeat transitions are ignored. No further pulse occurs until a `resetEvent` strobe.
- R7: A `resetEvent` strobe returns the timer to startup mode from any state and clears the count. `startupMode` reads 1 after that edge.
- R8: While `resetActive` is high, the count is held clear, no expiry is issued, and heartbeat transitions do not change the mode. Counting resumes from zero at the first edge after it falls.
- R9: While `enable` is low, the count is held clear, no expiry is issued, and transitions do not change the mode.
- R10: The count advances only on clocks where `tick` is high. Each clock without a tick delays expiry by one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; also starts a startup window |
| tick | input | 1 | Time-base strobe; one count per high cycle |
| heartbeat | input | 1 | Asynchronous heartbeat from the processor |
| enable | input | 1 | 1 = watchdog active, 0 = never expires |
| resetActive | input | 1 | High while system reset is asserted |
| resetEvent | input | 1 | One-clock strobe marking a new reset event |
| expirePulse | output | 1 | One-clock pulse requesting a reset |
| startupMode | output | 1 | 1 = long startup window (or idle after expiry), 0 = normal window |

## Verification
The heartbeat is driven four ways: held still, flipped once, toggled steadily faster than the normal window, and pulsed for a single clock. Each expiry is predicted to the exact cycle, so a single run separates the long window from the short one, an edge polarity that is missed from one that is counted, and a synchroniser that is one stage off. Timing runs with the heartbeat flipping during `resetActive` and during `enable` low check that those inputs really freeze the count, rather than merely hiding the output. A stretch without ticks shows that the count follows the time base and not the clock.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;

  typedef enum logic [1:0] {
    ST_STARTUP = 2'd0,
    ST_NORMAL  = 2'd1,
    ST_EXPIRED = 2'd2
  } wdState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;     // zero the tick count this cycle
    logic advance;   // count this cycle if a tick is present
    logic useNormal; // compare against the short window
  } wdStrobe_t;

endpackage

// File: rtl/wdog_datapath.sv
`timescale 1ns/1ps
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int START_TICKS  = 35000,
  parameter int NORMAL_TICKS = 1120,
  parameter int SYNC_STAGES  = 2,
  localparam int CNT_W = $clog2(START_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             heartbeat,
  input  logic             tick,
  input  wdStrobe_t        strobe,
  output logic             kick,
  output logic             atLimit,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] START_LIM  = CNT_W'(START_TICKS);
  localparam logic [CNT_W-1:0] NORMAL_LIM = CNT_W'(NORMAL_TICKS);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   hbDelayed;
  logic [CNT_W-1:0]       limitSel;

  // Synchroniser: one flop per stage
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncChain[0] <= 1'b0;
          else       syncChain[0] <= heartbeat;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncChain[s] <= 1'b0;
          else       syncChain[s] <= syncChain[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) hbDelayed <= 1'b0;
    else       hbDelayed <= syncChain[SYNC_STAGES-1];

  // Either polarity of transition is a kick
  assign kick = syncChain[SYNC_STAGES-1] ^ hbDelayed;

  assign limitSel = strobe.useNormal ? NORMAL_LIM : START_LIM;
  assign atLimit  = (count >= limitSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         count <= '0;
    else if (strobe.clear)             count <= '0;
    else if (strobe.advance && tick)   count <= count + CNT_W'(1);
  end

endmodule

// File: rtl/wdog_control.sv
`timescale 1ns/1ps
module wdog_control
  import wdog_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      resetActive,
  input  logic      resetEvent,
  input  logic      kick,
  input  logic      atLimit,
  output wdStrobe_t strobe,
  output logic      expirePulse,
  output logic      startupMode
);

  wdState_t state, stateNext;
  logic     expireNext;
  logic     armed;

  assign armed = enable && !resetActive;

  always_comb begin
    stateNext        = state;
    expireNext       = 1'b0;
    strobe.clear     = 1'b0;
    strobe.advance   = 1'b0;
    strobe.useNormal = (state == ST_NORMAL);
    if (resetEvent) begin
      stateNext    = ST_STARTUP;
      strobe.clear = 1'b1;
    end else begin
      case (state)
        ST_STARTUP, ST_NORMAL: begin
          if (!armed) begin
            strobe.clear = 1'b1;
          end else if (kick) begin
            strobe.clear = 1'b1;
            stateNext    = ST_NORMAL;
          end else if (atLimit) begin
            strobe.clear = 1'b1;
            expireNext   = 1'b1;
            stateNext    = ST_EXPIRED;
          end else begin
            strobe.advance = 1'b1;
          end
        end
        default: begin
          strobe.clear = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_STARTUP;
      expirePulse <= 1'b0;
    end else begin
      state       <= stateNext;
      expirePulse <= expireNext;
    end
  end

  assign startupMode = (state != ST_NORMAL);

endmodule

// File: rtl/dual_window_watchdog.sv
`timescale 1ns/1ps
module dual_window_watchdog
  import wdog_pkg::*;
#(
  parameter int START_TICKS  = 35000,
  parameter int NORMAL_TICKS = 1120,
  parameter int SYNC_STAGES  = 2,
  localparam int CNT_W = $clog2(START_TICKS + 1)
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic heartbeat,
  input  logic enable,
  input  logic resetActive,
  input  logic resetEvent,
  output logic expirePulse,
  output logic startupMode
);

  wdStrobe_t        strobe;
  logic             kick;
  logic             atLimit;
  logic [CNT_W-1:0] count;

  wdog_datapath #(
    .START_TICKS (START_TICKS),
    .NORMAL_TICKS(NORMAL_TICKS),
    .SYNC_STAGES (SYNC_STAGES)
  ) uDatapath (
    .clk      (clk),
    .rstN     (rstN),
    .heartbeat(heartbeat),
    .tick     (tick),
    .strobe   (strobe),
    .kick     (kick),
    .atLimit  (atLimit),
    .count    (count)
  );

  wdog_control uControl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .resetActive(resetActive),
    .resetEvent (resetEvent),
    .kick       (kick),
    .atLimit    (atLimit),
    .strobe     (strobe),
    .expirePulse(expirePulse),
    .startupMode(startupMode)
  );

endmodule

// File: rtl/wdog_checker.sv
`timescale 1ns/1ps
module wdog_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          tick,
  input logic          enable,
  input logic          resetActive,
  input logic          resetEvent,
  input logic          expirePulse,
  input logic          startupMode,
  input logic          kick,
  input logic [CW-1:0] count
);

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    expirePulse |=> !expirePulse);

  a_r6_idle_in_startup: assert property (@(posedge clk) disable iff (!rstN)
    expirePulse |-> startupMode);

  a_r7_event_to_startup: assert property (@(posedge clk) disable iff (!rstN)
    resetEvent |=> startupMode);

  a_r8_no_expire_in_reset: assert property (@(posedge clk) disable iff (!rstN)
    resetActive |=> !expirePulse);

  a_r8_count_held: assert property (@(posedge clk) disable iff (!rstN)
    resetActive |=> (count == '0));

  a_r9_disabled_silent: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !expirePulse);

  a_r3_normal_needs_kick: assert property (@(posedge clk) disable iff (!rstN)
    $fell(startupMode) |-> $past(kick));

  a_r10_count_steps: assert property (@(posedge clk) disable iff (!rstN)
    (count != $past(count)) |->
      ((count == '0) || ((count == ($past(count) + CW'(1))) && $past(tick))));

endmodule

bind dual_window_watchdog wdog_checker #(.CW(CNT_W)) uChecker (
  .clk        (clk),
  .rstN       (rstN),
  .tick       (tick),
  .enable     (enable),
  .resetActive(resetActive),
  .resetEvent (resetEvent),
  .expirePulse(expirePulse),
  .startupMode(startupMode),
  .kick       (kick),
  .count      (count)
);

// File: tb/dual_window_watchdog_test.sv
`timescale 1ns/1ps
module dual_window_watchdog_test;

  localparam int START = 40;
  localparam int NORM  = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b1;
  logic heartbeat = 1'b0;
  logic enable = 1'b1;
  logic resetActive = 1'b0;
  logic resetEvent = 1'b0;
  logic expirePulse;
  logic startupMode;

  int cycleNo = 0;
  int checks = 0;
  int errors = 0;
  int expQ[$];
  string tagQ[$];

  dual_window_watchdog #(
    .START_TICKS (START),
    .NORMAL_TICKS(NORM),
    .SYNC_STAGES (2)
  ) uut (
    .clk(clk), .rstN(rstN), .tick(tick), .heartbeat(heartbeat),
    .enable(enable), .resetActive(resetActive), .resetEvent(resetEvent),
    .expirePulse(expirePulse), .startupMode(startupMode)
  );

  always #2 clk = ~clk;

  always @(posedge clk) cycleNo <= cycleNo + 1;

  // Monitor: pops an expected expiry cycle for each observed pulse
  always @(negedge clk) begin
    if (rstN && expirePulse === 1'b1) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R6 unexpected expiry pulse at cycle %0d actual=1 expected=0", cycleNo);
      end else begin
        int eCyc;
        string eTag;
        eCyc = expQ.pop_front();
        eTag = tagQ.pop_front();
        if (eCyc != cycleNo) begin
          errors++;
          $display("FAIL %s expiry cycle actual=%0d expected=%0d", eTag, cycleNo, eCyc);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic expectAt(input int cyc, input string tag);
    expQ.push_back(cyc);
    tagQ.push_back(tag);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Strobe sampled at edge c+1
  task automatic pulseEvent(output int c);
    c = cycleNo;
    resetEvent = 1'b1;
    step(1);
    resetEvent = 1'b0;
  endtask

  // Heartbeat flip first captured at edge c+1
  task automatic flipHb(output int c);
    c = cycleNo;
    heartbeat = ~heartbeat;
    step(1);
  endtask

  initial begin
    int c, k, k2;
    step(5);
    chk(startupMode === 1'b1, "R1", startupMode, 1, "mode in reset");
    chk(expirePulse === 1'b0, "R1", expirePulse, 0, "pulse in reset");
    c = cycleNo;
    rstN = 1'b1;
    expectAt(c + START + 1, "R1");
    step(START + 8);
    chk(startupMode === 1'b1, "R6", startupMode, 1, "mode after expiry");
    flipHb(k);
    step(10);
    chk(startupMode === 1'b1, "R6", startupMode, 1, "kick ignored after expiry");

    // R2: long window with no kick
    pulseEvent(c);
    expectAt(c + START + 2, "R2");
    step(START + 8);
    chk(startupMode === 1'b1, "R6", startupMode, 1, "idle mode after startup expiry");

    // R3, R5: single transition switches to normal window
    pulseEvent(c);
    step(10);
    flipHb(k);
    step(1);
    chk(startupMode === 1'b1, "R5", startupMode, 1, "mode two edges after capture");
    step(1);
    chk(startupMode === 1'b0, "R3", startupMode, 0, "mode after first kick");
    expectAt(k + NORM + 4, "R5");
    step(NORM + 6);
    chk(startupMode === 1'b1, "R6", startupMode, 1, "idle mode after normal expiry");

    // R4: steady toggling of both polarities
    pulseEvent(c);
    step(3);
    for (int i = 0; i < 10; i++) begin
      flipHb(k);
      step(7);
    end
    chk(startupMode === 1'b0, "R4", startupMode, 0, "normal mode under toggling");
    expectAt(k + NORM + 4, "R4");
    step(NORM + 8);

    // R4: one-clock pulse gives two kicks
    pulseEvent(c);
    step(5);
    flipHb(k);
    flipHb(k2);
    step(2);
    chk(startupMode === 1'b0, "R4", startupMode, 0, "mode after one-clock pulse");
    expectAt(k2 + NORM + 4, "R4");
    step(NORM + 6);

    // R7: reset event from normal mode
    pulseEvent(c);
    step(4);
    flipHb(k);
    step(6);
    chk(startupMode === 1'b0, "R7", startupMode, 0, "normal before event");
    pulseEvent(c);
    chk(startupMode === 1'b1, "R7", startupMode, 1, "mode after event");
    expectAt(c + START + 2, "R7");
    step(START + 6);

    // R8: resetActive holds the counter clear
    pulseEvent(c);
    step(1);
    resetActive = 1'b1;
    step(5);
    flipHb(k);
    step(10);
    flipHb(k);
    step(START + 20);
    chk(startupMode === 1'b1, "R8", startupMode, 1, "kicks ignored in reset");
    c = cycleNo;
    resetActive = 1'b0;
    expectAt(c + START + 1, "R8");
    step(START + 6);

    // R9: enable low blocks expiry and kicks
    pulseEvent(c);
    step(1);
    enable = 1'b0;
    step(5);
    flipHb(k);
    step(10);
    flipHb(k);
    step(START + 20);
    chk(startupMode === 1'b1, "R9", startupMode, 1, "kicks ignored when disabled");
    c = cycleNo;
    enable = 1'b1;
    expectAt(c + START + 1, "R9");
    step(START + 6);

    // R10: no ticks, no counting
    pulseEvent(c);
    step(4);
    tick = 1'b0;
    step(30);
    tick = 1'b1;
    expectAt(c + START + 2 + 30, "R10");
    step(START + 10);

    step(5);
    chk(expQ.size() == 0, "R2", expQ.size(), 0, "expected pulses left unseen");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog timeout (all requirements) actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule